// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block takes the digital outputs of two analog comparators and turns selected transitions on them into sticky interrupt flags, then combines those flags into one interrupt request. Every channel first brings its asynchronous comparator output into the clock domain. It can then invert the result, and it watches the result for the kind of transition picked by a two-bit event selector.

Software works with the block through a small register bus. Each channel has a configuration register with its inversion, event selection and enable. A flag register can be read and written: writing 0 clears a flag and writing 1 forces it. A status register shows the conditioned comparator levels and also holds the peripheral-level and global interrupt enables. A flag records its event whatever the enables are. The enables only gate the request line.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: Each raw comparator input passes through two flip-flops before edge detection, and the previous-value register is loaded during reset, so a level held steady through reset never sets a flag afterwards in any event mode.
- R2: With the channel's invert bit (config bit 0) set, the status level is the complement of the raw input, and edges are judged on that complemented level.
- R3: Event select 00 (config bits 2:1) never sets the flag.
- R4: Event select 01 sets the flag on a 0-to-1 transition of the conditioned level only.
- R5: Event select 10 sets the flag on a 1-to-0 transition of the conditioned level only.
- R6: Event select 11 sets the flag on any transition of the conditioned level.
- R7: A flag stays set until a write of 0 to its bit in the flag register (address 2, bit n for channel n). Hardware never clears a flag.
- R8: Writing 1 to a flag bit sets that flag.
- R9: The interrupt request is a registered level. It is 1 one cycle after the OR over channels of (flag AND channel enable, config bit 3) is 1 while the peripheral enable (status bit 4) and the global enable (status bit 5) are both 1, and it is 0 otherwise.
- R10: A flag sets on its event even while its channel enable, the peripheral enable or the global enable is 0.
- R11: When an event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R12: Toggling the invert bit is treated as a change of the conditioned level and is subject to the event selection.
- R13: A read at address a (config at 0 and 1, flags at 2, status at 3, with conditioned levels in status bits 1:0) returns its data with read-valid on the cycle after the request.
- R14: After reset, all configuration fields, flags, enables and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | NCH | Asynchronous comparator outputs, one per channel |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 1 | Combined interrupt request, registered level |

## Verification
Each event mode gets both a rising and a falling raw transition, so the bench can tell a mode that reacts to the correct edge apart from one that reacts to both edges or to neither. The inverted channel gets the same pair of transitions and also gets toggles of the invert bit alone with the raw input held steady. This separates inversion applied before the edge detector from inversion applied only on the read path. Enables are switched on one at a time while a flag is pending, and the request line is sampled on the cycle of the switch and on the cycle after it, which checks both the full AND gating and the one-cycle register stage. A flag clear is written in exactly the cycle an edge arrives, to test that the set takes priority.

// File: rtl/cmp_irq_pkg.sv
// Shared types and register layout for the comparator edge interrupt controller.
package cmp_irq_pkg;

    // Event selector encoding; values are visible to software.
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_RISE = 2'b01,
        EV_FALL = 2'b10,
        EV_ANY  = 2'b11
    } evsel_e;

    // Per-channel configuration word: {enable, select[1:0], invert}.
    localparam int CFG_W     = 4;
    localparam int CFG_INV   = 0;
    localparam int CFG_SEL_L = 1;
    localparam int CFG_EN    = 3;

    // Status register enable bit positions.
    localparam int STS_PE    = 4;
    localparam int STS_GE    = 5;

endpackage

// File: rtl/cmp_irq_sync.sv
// Multi-stage synchronizer for one asynchronous comparator level.
// Assumes the input is a slow level; the stages carry no reset so they
// keep sampling while reset is held and are settled when it releases.
module cmp_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the stage chain.
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cmp_irq_chan.sv
// One comparator channel: synchronize, optionally invert, detect the
// selected transition and hold a sticky flag.
// Assumes inv_i resets to 0 together with this module so the previous-level
// register captures the synchronized level during reset.
module cmp_irq_chan
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic       inv_i,
    input  logic [1:0] sel_i,
    input  logic       sw_wr_i,
    input  logic       sw_val_i,
    output logic       level_o,
    output logic       flag_o
);
    logic   synced;
    logic   level;
    logic   prev_q;
    logic   flag_q;
    logic   rise;
    logic   fall;
    logic   hit;
    evsel_e sel;

    cmp_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw_i),
        .q_o (synced)
    );

    assign sel   = evsel_e'(sel_i);
    assign level = synced ^ inv_i;
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

    // Pick which transition raises the flag.
    always_comb begin
        unique case (sel)
            EV_NONE: hit = 1'b0;
            EV_RISE: hit = rise;
            EV_FALL: hit = fall;
            EV_ANY:  hit = rise | fall;
            default: hit = 1'b0;
        endcase
    end

    // Remember the conditioned level; loaded during reset to avoid a false edge.
    always_ff @(posedge clk) begin
        prev_q <= level;
    end

    // Sticky flag: event sets, software write sets or clears, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= hit | (sw_wr_i ? sw_val_i : flag_q);
        end
    end

    assign level_o = level;
    assign flag_o  = flag_q;

    // R7: hardware never drops a flag
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(sw_wr_i && !sw_val_i)) |=> flag_q);

    // R3: mode none stays quiet
    p_none_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_NONE && !flag_q && !(sw_wr_i && sw_val_i)) |=> !flag_q);

    // R4: rising transition recorded
    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_RISE && level && !prev_q) |=> flag_q);

    // R5: falling transition recorded
    p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_FALL && !level && prev_q) |=> flag_q);

    // R8: software set
    p_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_val_i) |=> flag_q);

    // R11: event beats a same-cycle clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_ANY && (level != prev_q) && sw_wr_i && !sw_val_i) |=> flag_q);

endmodule

// File: rtl/cmp_irq_regs.sv
// Register file: per-channel configuration, flag write strobes, enables and
// the registered read path. Assumes one access per cycle on the bus.
module cmp_irq_regs
    import cmp_irq_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2,
    parameter int DW  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_rvalid,
    input  logic [NCH-1:0]      flags_i,
    input  logic [NCH-1:0]      level_i,
    output logic [NCH-1:0]      inv_o,
    output logic [NCH-1:0]      en_o,
    output logic [NCH-1:0][1:0] sel_o,
    output logic                pe_o,
    output logic                ge_o,
    output logic                flag_wr_o,
    output logic [NCH-1:0]      flag_wdata_o
);
    localparam int FLG_ADDR = NCH;
    localparam int STS_ADDR = NCH + 1;

    logic [CFG_W-1:0] cfg_q [NCH];
    logic             pe_q;
    logic             ge_q;
    logic             wr_any;
    logic             rd_any;
    logic [DW-1:0]    rd_mux;

    assign wr_any = bus_valid & bus_write;
    assign rd_any = bus_valid & ~bus_write;

    for (genvar c = 0; c < NCH; c++) begin : g_cfg
        // Hold one channel's configuration word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[c] <= '0;
            end else if (wr_any && bus_addr == AW'(c)) begin
                cfg_q[c] <= bus_wdata[CFG_W-1:0];
            end
        end
        assign inv_o[c] = cfg_q[c][CFG_INV];
        assign en_o[c]  = cfg_q[c][CFG_EN];
        assign sel_o[c] = cfg_q[c][CFG_SEL_L +: 2];
    end

    // Hold the peripheral and global enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q <= 1'b0;
            ge_q <= 1'b0;
        end else if (wr_any && bus_addr == AW'(STS_ADDR)) begin
            pe_q <= bus_wdata[STS_PE];
            ge_q <= bus_wdata[STS_GE];
        end
    end

    assign flag_wr_o    = wr_any && (bus_addr == AW'(FLG_ADDR));
    assign flag_wdata_o = bus_wdata[NCH-1:0];
    assign pe_o         = pe_q;
    assign ge_o         = ge_q;

    // Select the word addressed by a read.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(c)) begin
                rd_mux[CFG_W-1:0] = cfg_q[c];
            end
        end
        if (bus_addr == AW'(FLG_ADDR)) begin
            rd_mux[NCH-1:0] = flags_i;
        end
        if (bus_addr == AW'(STS_ADDR)) begin
            rd_mux[NCH-1:0] = level_i;
            rd_mux[STS_PE]  = pe_q;
            rd_mux[STS_GE]  = ge_q;
        end
    end

    // Register read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_any;
            if (rd_any) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    // R13: every read answers on the next cycle
    p_read_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> bus_rvalid);

    // R13: no answer without a request
    p_no_spurious_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !bus_rvalid);

endmodule

// File: rtl/cmp_irq_ctrl.sv
// Top: comparator edge interrupt controller. Instantiates one channel per
// comparator, the register file and the registered request gate.
// Assumes NCH <= 4 so the levels fit below the enable bits of status.
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = STS_GE + 1,
    parameter int AW          = $clog2(NCH + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_raw,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_rvalid,
    output logic           irq
);
    logic [NCH-1:0]      inv;
    logic [NCH-1:0]      en;
    logic [NCH-1:0][1:0] sel;
    logic [NCH-1:0]      flags;
    logic [NCH-1:0]      levels;
    logic [NCH-1:0]      flag_wdata;
    logic                flag_wr;
    logic                pe;
    logic                ge;
    logic                irq_q;
    logic                req_now;

    cmp_irq_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .flags_i      (flags),
        .level_i      (levels),
        .inv_o        (inv),
        .en_o         (en),
        .sel_o        (sel),
        .pe_o         (pe),
        .ge_o         (ge),
        .flag_wr_o    (flag_wr),
        .flag_wdata_o (flag_wdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cmp_irq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (cmp_raw[c]),
            .inv_i    (inv[c]),
            .sel_i    (sel[c]),
            .sw_wr_i  (flag_wr),
            .sw_val_i (flag_wdata[c]),
            .level_o  (levels[c]),
            .flag_o   (flags[c])
        );
    end

    assign req_now = (|(flags & en)) & pe & ge;

    // Register the combined request level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= req_now;
        end
    end

    assign irq = irq_q;

    // R9: global enable off keeps the request low
    p_ge_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ge |=> !irq);

    // R9: peripheral enable off keeps the request low
    p_pe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |=> !irq);

    // R9: pending enabled flag raises the request a cycle later
    p_req_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & en) && pe && ge) |=> irq);

endmodule

// File: tb/cmp_irq_ctrl_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them when read data returns; request-line checks are direct.
module cmp_irq_ctrl_tb;
    localparam int NCH   = 2;
    localparam int DW    = 6;
    localparam int AW    = 2;
    localparam int A_C0  = 0;
    localparam int A_C1  = 1;
    localparam int A_FLG = 2;
    localparam int A_STS = 3;
    // config word {en, sel[1:0], inv}
    localparam int C_NONE = 0, C_RISE = 2, C_FALL = 4, C_ANY = 6, C_INV = 1, C_EN = 8;
    localparam int S_PE = 16, S_GE = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cmp_raw = '0;
    logic           bus_valid = 1'b0;
    logic           bus_write = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           bus_rvalid;
    logic           irq;

    int    n_checks = 0;
    int    n_errors = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    finished = 1'b0;

    cmp_irq_ctrl #(.NCH(NCH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw    (cmp_raw),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq        (irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic wr(input int addr, input int data);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr  = AW'(addr); bus_wdata = DW'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int addr, input int exp, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pop and compare each returned read word.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected read data", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            check("watchdog expired", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        cmp_raw = 2'b01;
        idle(6);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        check("R14 irq after reset", int'(irq), 0);
        rd(A_C0, 0, "R14 cfg0 reset");
        rd(A_FLG, 0, "R14 flags reset");
        rd(A_STS, 6'h01, "R13 status shows levels");

        // R1 steady level through reset gives no edge
        wr(A_C0, C_ANY);
        idle(6);
        rd(A_FLG, 0, "R1 no false edge");

        // R6 any change, both directions
        cmp_raw[0] = 1'b0; idle(6);
        rd(A_FLG, 1, "R6 fall in any mode");
        wr(A_FLG, 0);
        rd(A_FLG, 0, "R7 clear by writing 0");
        cmp_raw[0] = 1'b1; idle(6);
        rd(A_FLG, 1, "R6 rise in any mode");
        idle(6);
        rd(A_FLG, 1, "R7 flag sticky");
        wr(A_FLG, 0);

        // R4 rising only
        wr(A_C1, C_RISE);
        cmp_raw[1] = 1'b1; idle(6);
        rd(A_FLG, 2, "R4 rise sets");
        wr(A_FLG, 0);
        cmp_raw[1] = 1'b0; idle(6);
        rd(A_FLG, 0, "R4 fall ignored");

        // R5 falling only
        wr(A_C1, C_FALL);
        cmp_raw[1] = 1'b1; idle(6);
        rd(A_FLG, 0, "R5 rise ignored");
        cmp_raw[1] = 1'b0; idle(6);
        rd(A_FLG, 2, "R5 fall sets");
        wr(A_FLG, 0);

        // R3 none
        wr(A_C1, C_NONE);
        cmp_raw[1] = 1'b1; idle(6);
        cmp_raw[1] = 1'b0; idle(6);
        rd(A_FLG, 0, "R3 none never sets");

        // R2 inversion of status
        wr(A_C1, C_INV);
        idle(4);
        rd(A_STS, 6'h03, "R2 inverted level in status");

        // R12 invert toggle counts as a change
        wr(A_C1, C_INV | C_RISE);
        idle(3);
        rd(A_FLG, 0, "R12 no change no flag");
        wr(A_C1, C_RISE);
        idle(3);
        rd(A_FLG, 0, "R12 toggle to falling ignored in rise mode");
        wr(A_C1, C_INV | C_RISE);
        idle(3);
        rd(A_FLG, 2, "R12 toggle to rising sets");
        wr(A_FLG, 0);

        // R2 edges judged after inversion
        cmp_raw[1] = 1'b1; idle(6);
        rd(A_FLG, 0, "R2 raw rise is conditioned fall");
        cmp_raw[1] = 1'b0; idle(6);
        rd(A_FLG, 2, "R2 raw fall is conditioned rise");
        wr(A_FLG, 0);
        wr(A_C1, C_NONE);

        // R8 software set; R10 flags set with enables off
        wr(A_FLG, 1);
        rd(A_FLG, 1, "R8 write 1 sets flag");
        idle(2);
        check("R10 flag pending with enables off, irq low", int'(irq), 0);

        // R9 gating and register stage
        wr(A_C0, C_ANY | C_EN);
        wr(A_STS, S_PE);
        idle(2);
        check("R9 global enable off", int'(irq), 0);
        wr(A_STS, S_PE | S_GE);
        check("R9 irq one cycle late", int'(irq), 0);
        @(negedge clk);
        check("R9 irq asserted", int'(irq), 1);
        rd(A_STS, S_PE | S_GE | 1, "R13 status enables readback");
        wr(A_STS, S_GE);
        @(negedge clk);
        check("R9 peripheral enable off", int'(irq), 0);
        wr(A_STS, S_PE | S_GE);
        wr(A_C0, C_ANY);
        @(negedge clk);
        check("R9 channel enable off", int'(irq), 0);
        wr(A_C0, C_ANY | C_EN);
        wr(A_FLG, 0);
        @(negedge clk);
        check("R9 flag cleared", int'(irq), 0);

        // R11 event beats same-cycle clear
        wr(A_FLG, 1);
        cmp_raw[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(A_FLG, 0);
        rd(A_FLG, 1, "R11 set wins over clear");
        wr(A_FLG, 0);
        rd(A_FLG, 0, "R7 later clear works");

        idle(4);
        check("R13 all reads answered", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule